// File: doc/BRIEF.md
# Adapter Module Power Sequencer

This block decides when a pluggable I/O adapter module on an FPGA carrier may draw power. It watches an active-low presence line that the module pulls down when it is seated. After insertion it powers only the small rail that feeds the module's identification memory. It waits a programmable settle time, then asks an external ID reader for the module ID through a request/valid handshake. It compares the returned ID with the expected ID that the loaded configuration supplies.

Only a matching module gets its main supply rails. The module's I/O output enables are released one cycle after those rails come up. A mismatch or a silent reader leaves every rail off and the I/O tri-stated. A user power-down command latches the module dark. Power then returns only through a reset, a configuration load or a removal and reinsertion of the module. Reset is a pulse and not a held state: once it is released, a module that is still present is sequenced again at once.

Status outputs report the sequencer state, the last ID read, a match flag, a user-disabled flag and a read-timeout flag.

Top module: `adp_pwr_seq`

## Requirements
- R1: While `rst_n` is low, every rail and I/O enable is off, `seq_state` is 0 (idle) and the match, user-off and timeout flags are 0. After `rst_n` returns high, a module that is still present is powered up again with no other input.
- R2: With `mod_id_n` high the block stays idle with every rail off. Once `mod_id_n` has been low for the synchronizer depth, `seq_state` becomes 1 (settle) and only `id_rail_en` is high.
- R3: `id_req` rises exactly `settle_cycles`+1 cycles after `id_rail_en` rises. It stays high only while the ID rail is on and the main rails are off, until `id_vld` arrives or the read times out.
- R4: If `id_data` equals `cfg_exp_id` when `id_vld` is high, all `main_rail_en` bits turn on with `io_oe` still 0 (`seq_state` 3). One cycle later every `io_oe` bit is 1 and `seq_state` is 4. `id_match` becomes 1 and `last_id` holds the ID that was read.
- R5: If the returned ID differs from `cfg_exp_id`, every rail stays off, `io_oe` stays 0, `seq_state` goes to 5 (blocked) and stays there, and `id_match` is 0.
- R6: If no `id_vld` arrives during the `TIMEOUT_CYCLES`+1 cycles that `id_req` is high, the block enters `seq_state` 5 with every rail off and sets `id_timeout`.
- R7: A one-cycle pulse on `usr_pwr_off` turns every rail and I/O enable off, gives `seq_state` 6 and sets `user_off`. This holds for as long as the module stays present and no reset or configuration load occurs.
- R8: A one-cycle pulse on `cfg_load` restarts the sequence at `seq_state` 1 from any state while a module is present. It clears the match, user-off and timeout flags, and the new check uses the current `cfg_exp_id`.
- R9: When `mod_id_n` goes high, every rail and I/O enable goes off and `seq_state` returns to 0 once the synchronizer has passed the change. A later reinsertion runs the full sequence even after a user power-down.
- R10: When `cfg_load` and `usr_pwr_off` pulse in the same cycle, the configuration load wins and the block enters `seq_state` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset pulse |
| mod_id_n | input | 1 | Presence line, low while a module is seated |
| cfg_exp_id | input | ID_W | Expected module ID of the loaded configuration |
| cfg_load | input | 1 | One-cycle pulse: a configuration was loaded |
| usr_pwr_off | input | 1 | One-cycle user power-down command |
| settle_cycles | input | SETTLE_W | ID-rail settle delay in cycles |
| id_req | output | 1 | Request to the external ID reader |
| id_vld | input | 1 | ID reader result valid |
| id_data | input | ID_W | Module ID returned by the reader |
| id_rail_en | output | 1 | Enable for the ID-memory supply rail |
| main_rail_en | output | MAIN_RAILS | Enables for the main supply rails |
| io_oe | output | IO_W | Module I/O output enables (0 means tri-state) |
| seq_state | output | 3 | Sequencer state code |
| last_id | output | ID_W | Last ID returned by the reader |
| id_match | output | 1 | Last read ID matched the expected ID |
| user_off | output | 1 | Module is held off by a user command |
| id_timeout | output | 1 | Last ID read timed out |

## Verification
The assertions assume that `id_vld` is only meaningful while `id_req` is high, and that `cfg_load` and `usr_pwr_off` are single-cycle pulses. They also assume the presence line holds steady for longer than the synchronizer depth. The bench's reader model raises `id_vld` for one cycle, a fixed latency after it sees `id_req`, and drops it as soon as the request goes away. Every command pulse is driven for exactly one cycle on the falling edge. The presence line only changes when the bench then waits several cycles, so no glitch shorter than the synchronizer ever reaches the block.

// File: rtl/adp_pwr_pkg.sv
package adp_pwr_pkg;

   // State codes are visible on seq_state; values are part of the interface.
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_READ   = 3'd2,
      ST_RAMP   = 3'd3,
      ST_ON     = 3'd4,
      ST_BLOCK  = 3'd5,
      ST_UOFF   = 3'd6
   } seq_st_e;

endpackage

// File: rtl/adp_pwr_sync.sv
module adp_pwr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("adp_pwr_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/adp_pwr_timer.sv
module adp_pwr_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (run && cnt != '0)    cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/adp_pwr_seq.sv
module adp_pwr_seq
   import adp_pwr_pkg::*;
#(
   parameter int ID_W           = 8,
   parameter int MAIN_RAILS     = 3,
   parameter int IO_W           = 4,
   parameter int SETTLE_W       = 16,
   parameter int TIMEOUT_CYCLES = 1024,
   parameter int SYNC_STAGES    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mod_id_n,
   input  logic [ID_W-1:0]       cfg_exp_id,
   input  logic                  cfg_load,
   input  logic                  usr_pwr_off,
   input  logic [SETTLE_W-1:0]   settle_cycles,
   output logic                  id_req,
   input  logic                  id_vld,
   input  logic [ID_W-1:0]       id_data,
   output logic                  id_rail_en,
   output logic [MAIN_RAILS-1:0] main_rail_en,
   output logic [IO_W-1:0]       io_oe,
   output logic [2:0]            seq_state,
   output logic [ID_W-1:0]       last_id,
   output logic                  id_match,
   output logic                  user_off,
   output logic                  id_timeout
);

   localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);

   if (ID_W < 1 || MAIN_RAILS < 1 || IO_W < 1 || SETTLE_W < 1) begin : g_bad_width
      $error("adp_pwr_seq: widths and counts must be at least 1");
   end
   if (TIMEOUT_CYCLES < 1) begin : g_bad_timeout
      $error("adp_pwr_seq: TIMEOUT_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("adp_pwr_seq: SYNC_STAGES must be at least 1");
   end

   seq_st_e st_q, st_d;
   logic    mod_id_s, present;
   logic    enter_settle, enter_read;
   logic    settle_zero, to_zero;
   logic    id_ok;
   logic    rail_id_on, rail_main_on, rail_io_on;

   // presence line crosses in from the connector
   adp_pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mod_id_n),
      .q     (mod_id_s)
   );
   assign present = ~mod_id_s;
   assign id_ok   = (id_data == cfg_exp_id);

   // next-state: removal beats reload, reload beats user power-down
   always_comb begin
      st_d         = st_q;
      enter_settle = 1'b0;
      if (!present) begin
         st_d = ST_IDLE;
      end else if (cfg_load) begin
         st_d         = ST_SETTLE;
         enter_settle = 1'b1;
      end else if (usr_pwr_off && st_q != ST_IDLE) begin
         st_d = ST_UOFF;
      end else begin
         case (st_q)
            ST_IDLE: begin
               st_d         = ST_SETTLE;
               enter_settle = 1'b1;
            end
            ST_SETTLE: if (settle_zero) st_d = ST_READ;
            ST_READ: begin
               if (id_vld)       st_d = id_ok ? ST_RAMP : ST_BLOCK;
               else if (to_zero) st_d = ST_BLOCK;
            end
            ST_RAMP: st_d = ST_ON;
            default: st_d = st_q;
         endcase
      end
   end

   assign enter_read = (st_d == ST_READ) && (st_q != ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   adp_pwr_timer #(.W(SETTLE_W)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (enter_settle),
      .load_val (settle_cycles),
      .run      (st_q == ST_SETTLE),
      .zero     (settle_zero)
   );

   adp_pwr_timer #(.W(TO_W)) u_timeout (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (enter_read),
      .load_val (TO_W'(TIMEOUT_CYCLES)),
      .run      (st_q == ST_READ),
      .zero     (to_zero)
   );

   // status flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_id    <= '0;
         id_match   <= 1'b0;
         user_off   <= 1'b0;
         id_timeout <= 1'b0;
      end else if (enter_settle || st_d == ST_IDLE) begin
         id_match   <= 1'b0;
         user_off   <= 1'b0;
         id_timeout <= 1'b0;
      end else begin
         if (st_q == ST_READ && id_vld) begin
            last_id  <= id_data;
            id_match <= id_ok;
         end else if (st_q == ST_READ && st_d == ST_BLOCK) begin
            id_timeout <= 1'b1;
         end
         if (st_d == ST_UOFF) user_off <= 1'b1;
      end
   end

   // rail decode from the registered state only
   always_comb begin
      rail_id_on   = 1'b0;
      rail_main_on = 1'b0;
      rail_io_on   = 1'b0;
      case (st_q)
         ST_SETTLE, ST_READ: rail_id_on = 1'b1;
         ST_RAMP: begin
            rail_id_on   = 1'b1;
            rail_main_on = 1'b1;
         end
         ST_ON: begin
            rail_id_on   = 1'b1;
            rail_main_on = 1'b1;
            rail_io_on   = 1'b1;
         end
         default: ;
      endcase
   end

   for (genvar r = 0; r < MAIN_RAILS; r++) begin : g_rail
      assign main_rail_en[r] = rail_main_on;
   end
   for (genvar b = 0; b < IO_W; b++) begin : g_oe
      assign io_oe[b] = rail_io_on;
   end

   assign id_rail_en = rail_id_on;
   assign id_req     = (st_q == ST_READ);
   assign seq_state  = st_q;

endmodule

// File: rtl/adp_pwr_chk.sv
module adp_pwr_chk #(
   parameter int ID_W        = 8,
   parameter int MAIN_RAILS  = 3,
   parameter int IO_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  mod_id_n,
   input logic [ID_W-1:0]       cfg_exp_id,
   input logic                  id_req,
   input logic                  id_vld,
   input logic [ID_W-1:0]       id_data,
   input logic                  id_rail_en,
   input logic [MAIN_RAILS-1:0] main_rail_en,
   input logic [IO_W-1:0]       io_oe,
   input logic                  id_match,
   input logic                  user_off,
   input logic                  id_timeout
);

   // history of the raw presence line, long enough to cover the synchronizer
   logic [SYNC_STAGES:0] gone_hist;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gone_hist <= '0;
      else        gone_hist <= {gone_hist[SYNC_STAGES-1:0], mod_id_n};
   end

   a_r4_main_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      (|main_rail_en) |-> id_match);

   a_r4_io_after_rails: assert property (@(posedge clk) disable iff (!rst_n)
      (|io_oe) |-> ((|main_rail_en) && $past(|main_rail_en)));

   a_r3_req_on_id_rail: assert property (@(posedge clk) disable iff (!rst_n)
      id_req |-> (id_rail_en && !(|main_rail_en)));

   a_r5_mismatch_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (id_req && id_vld && id_data != cfg_exp_id) |=> !(|main_rail_en));

   a_r6_timeout_dark: assert property (@(posedge clk) disable iff (!rst_n)
      id_timeout |-> (!id_match && !(|main_rail_en)));

   a_r7_user_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
      user_off |-> (!id_rail_en && !(|main_rail_en) && !(|io_oe)));

   a_r9_removed_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (&gone_hist) |-> (!id_rail_en && !(|main_rail_en) && !(|io_oe)));

endmodule

bind adp_pwr_seq adp_pwr_chk #(
   .ID_W        (ID_W),
   .MAIN_RAILS  (MAIN_RAILS),
   .IO_W        (IO_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mod_id_n     (mod_id_n),
   .cfg_exp_id   (cfg_exp_id),
   .id_req       (id_req),
   .id_vld       (id_vld),
   .id_data      (id_data),
   .id_rail_en   (id_rail_en),
   .main_rail_en (main_rail_en),
   .io_oe        (io_oe),
   .id_match     (id_match),
   .user_off     (user_off),
   .id_timeout   (id_timeout)
);

// File: tb/tb_adp_pwr_seq.sv
module tb_adp_pwr_seq;

   localparam int ID_W = 8;
   localparam int MR   = 3;
   localparam int IOW  = 4;
   localparam int SW   = 8;
   localparam int TO   = 20;
   localparam int SET  = 5;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            mod_id_n;
   logic [ID_W-1:0] cfg_exp_id;
   logic            cfg_load;
   logic            usr_pwr_off;
   logic [SW-1:0]   settle_cycles;
   logic            id_req;
   logic            id_vld;
   logic [ID_W-1:0] id_data;
   logic            id_rail_en;
   logic [MR-1:0]   main_rail_en;
   logic [IOW-1:0]  io_oe;
   logic [2:0]      seq_state;
   logic [ID_W-1:0] last_id;
   logic            id_match, user_off, id_timeout;

   logic            mute;
   logic [ID_W-1:0] rsp_id;
   int              n_chk  = 0;
   int              n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   adp_pwr_seq #(
      .ID_W(ID_W), .MAIN_RAILS(MR), .IO_W(IOW), .SETTLE_W(SW),
      .TIMEOUT_CYCLES(TO), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .mod_id_n(mod_id_n), .cfg_exp_id(cfg_exp_id),
      .cfg_load(cfg_load), .usr_pwr_off(usr_pwr_off), .settle_cycles(settle_cycles),
      .id_req(id_req), .id_vld(id_vld), .id_data(id_data), .id_rail_en(id_rail_en),
      .main_rail_en(main_rail_en), .io_oe(io_oe), .seq_state(seq_state),
      .last_id(last_id), .id_match(id_match), .user_off(user_off),
      .id_timeout(id_timeout)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // scoreboard
   typedef struct {
      string          req;
      logic [2:0]     st;
      logic           idr;
      logic [MR-1:0]  mr;
      logic [IOW-1:0] oe;
      logic           m;
      logic           u;
      logic           t;
   } exp_t;

   exp_t exp_q[$];
   event sb_ev;

   task automatic push(string req, logic [2:0] st, logic idr, logic mron,
                       logic oeon, logic m, logic u, logic t);
      exp_t e;
      e.req = req; e.st = st; e.idr = idr;
      e.mr = {MR{mron}}; e.oe = {IOW{oeon}};
      e.m = m; e.u = u; e.t = t;
      exp_q.push_back(e);
      ->sb_ev;
      #1;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(sb_ev);
         while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk({e.req, " state"},      32'(seq_state),    32'(e.st));
            chk({e.req, " id rail"},    32'(id_rail_en),   32'(e.idr));
            chk({e.req, " main rails"}, 32'(main_rail_en), 32'(e.mr));
            chk({e.req, " io_oe"},      32'(io_oe),        32'(e.oe));
            chk({e.req, " match"},      32'(id_match),     32'(e.m));
            chk({e.req, " user_off"},   32'(user_off),     32'(e.u));
            chk({e.req, " timeout"},    32'(id_timeout),   32'(e.t));
         end
      end
   end

   // ID reader model: answers three cycles after the request is seen
   initial begin : reader
      int lat;
      lat = 0; id_vld = 1'b0; id_data = '0;
      forever begin
         @(negedge clk);
         if (id_req && !mute && !id_vld) begin
            lat++;
            if (lat == 3) begin
               id_vld = 1'b1; id_data = rsp_id; lat = 0;
            end
         end else begin
            id_vld = 1'b0; lat = 0;
         end
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
   end

   task automatic wait_st(logic [2:0] s, int max);
      for (int i = 0; i < max; i++) begin
         if (seq_state == s) break;
         @(negedge clk);
      end
   endtask

   task automatic pulse_load();
      cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
   endtask

   task automatic pulse_off();
      usr_pwr_off = 1'b1; @(negedge clk); usr_pwr_off = 1'b0;
   endtask

   initial begin : driver
      int n;
      rst_n = 1'b0; mod_id_n = 1'b1; cfg_exp_id = 8'h5A; cfg_load = 1'b0;
      usr_pwr_off = 1'b0; settle_cycles = SW'(SET); rsp_id = 8'h5A; mute = 1'b0;

      repeat (3) @(negedge clk);
      push("R1 in reset", 3'd0, 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      push("R2 no module", 3'd0, 0, 0, 0, 0, 0, 0);

      // insertion and settle timing
      mod_id_n = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (id_rail_en) break;
      end
      push("R2 inserted", 3'd1, 1, 0, 0, 0, 0, 0);
      n = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (id_req) break;
         n++;
      end
      chk("R3 settle cycles before id_req", 32'(n), 32'(SET + 1));

      // match: rails first, I/O one cycle later
      for (int i = 0; i < 20; i++) begin
         if (|main_rail_en) break;
         @(negedge clk);
      end
      chk("R4 io_oe held while rails ramp", 32'(io_oe), 32'h0);
      chk("R4 ramp state", 32'(seq_state), 32'd3);
      @(negedge clk);
      push("R4 powered", 3'd4, 1, 1, 1, 1, 0, 0);
      chk("R4 last_id", 32'(last_id), 32'h5A);

      // user power-down latches
      pulse_off();
      push("R7 user off", 3'd6, 0, 0, 0, 1, 1, 0);
      repeat (20) @(negedge clk);
      push("R7 user off holds", 3'd6, 0, 0, 0, 1, 1, 0);

      // reload re-runs the check
      pulse_load();
      push("R8 reload restarts", 3'd1, 1, 0, 0, 0, 0, 0);
      wait_st(3'd4, 60);
      push("R8 reload powered", 3'd4, 1, 1, 1, 1, 0, 0);

      // reload with a different expected ID
      cfg_exp_id = 8'h33;
      pulse_load();
      wait_st(3'd5, 60);
      push("R5 mismatch blocked", 3'd5, 0, 0, 0, 0, 0, 0);
      chk("R5 last_id keeps read value", 32'(last_id), 32'h5A);
      repeat (20) @(negedge clk);
      push("R5 blocked holds", 3'd5, 0, 0, 0, 0, 0, 0);

      // silent reader
      cfg_exp_id = 8'h5A; mute = 1'b1;
      pulse_load();
      for (int i = 0; i < 40; i++) begin
         if (id_req) break;
         @(negedge clk);
      end
      n = 0;
      for (int i = 0; i < 100; i++) begin
         if (!id_req) break;
         n++;
         @(negedge clk);
      end
      chk("R6 request window", 32'(n), 32'(TO + 1));
      push("R6 timed out", 3'd5, 0, 0, 0, 0, 0, 1);

      // removal
      mute = 1'b0;
      pulse_load();
      wait_st(3'd4, 60);
      mod_id_n = 1'b1;
      repeat (3) @(negedge clk);
      push("R9 removed", 3'd0, 0, 0, 0, 0, 0, 0);

      // reinsertion after user power-down
      mod_id_n = 1'b0;
      wait_st(3'd4, 60);
      pulse_off();
      mod_id_n = 1'b1;
      repeat (5) @(negedge clk);
      mod_id_n = 1'b0;
      wait_st(3'd4, 60);
      push("R9 reinserted", 3'd4, 1, 1, 1, 1, 0, 0);

      // reload beats power-down
      cfg_load = 1'b1; usr_pwr_off = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0; usr_pwr_off = 1'b0;
      push("R10 reload wins", 3'd1, 1, 0, 0, 0, 0, 0);
      wait_st(3'd4, 60);

      // reset pulse with module still present
      rst_n = 1'b0;
      @(negedge clk);
      push("R1 reset pulse", 3'd0, 0, 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      wait_st(3'd4, 60);
      push("R1 reinit after reset", 3'd4, 1, 1, 1, 1, 0, 0);

      repeat (2) @(negedge clk);
      report();
   end

endmodule